// File: doc/BRIEF.md
# Configurable GPIO Port with Control-Bit Variant

This block is one memory-mapped bidirectional I/O port of parameterised width (eight bits by default). Software sets it up through three registers on a small register bus: a configuration register, an output-data register and a read-only register that returns the synchronised pin levels. For every bit, the configuration bit and the data bit together pick one of four pin set-ups: floating input, input with weak pull-up, driven low or driven high. Each bit is set up on its own.

A parameter selects a control-port variant. In that variant the two top bits are not general pins. A write of 1 to the top data bit sends a one-cycle HALT request. A write of 1 to the next data bit sends a one-cycle IDLE request. These data bits are not stored. The two top configuration bits are stored and drive the serial-clock alternate-phase select and the post-HALT clock start-up delay enable. The variant also has a watchdog takeover input. When it is asserted, pin 1 carries the watchdog level with a weak pull-up, and the register bits for pin 1 no longer affect that pin.

Top module: `gpio_port`

## Requirements
- R1: During and right after reset, both the configuration and data registers read 0. Every pin has output enable 0, pull-up 0 and output value 0, and all request and option outputs are 0.
- R2: The per-bit encoding is as follows. cfg=0, data=0 gives a floating input (oe=0, pu=0). cfg=0, data=1 gives an input with pull-up (oe=0, pu=1). cfg=1, data=0 drives low (oe=1, out=0). cfg=1, data=1 drives high (oe=1, out=1). Whenever oe=0, out is 0.
- R3: Address 0 holds the configuration and address 1 holds the data. A write with bus_we=1 takes effect on that clock edge. Reads return the stored values bit by bit, and every bit is independent of the others. Address 3 reads 0.
- R4: Address 2 returns pad_in delayed by two clock edges. Writes to address 2 change nothing.
- R5: In the control variant, data bits 7 and 6 always read 0. A data write with bit 7 set makes halt_req 1 for exactly the cycle after the write edge. A data write with bit 6 set does the same for idle_req.
- R6: In the control variant, configuration bit 6 drives sk_alt_phase and configuration bit 7 drives halt_start_dly. Both bits read back as stored.
- R7: In the control variant, pins 6 and 7 never have output enable or pull-up set, whatever the register contents.
- R8: In the control variant with wdog_sel=1, pin 1 has oe=1, pu=1 and out=wdog_level, whatever the configuration and data bit 1 hold.
- R9: In the plain variant, all bits including 6 and 7 behave as in R2 and R3, halt_req and idle_req stay 0, and the option outputs stay 0.
- R10: With wdog_sel=0, pin 1 of the control variant follows R2 like any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 configuration, 1 data, 2 pin levels |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr |
| wdog_sel | input | 1 | Watchdog takes over pin 1 (control variant) |
| wdog_level | input | 1 | Watchdog output level |
| pad_in | input | WIDTH | Pin input levels |
| pad_out | output | WIDTH | Pin output values |
| pad_oe | output | WIDTH | Pin output enables |
| pad_pu | output | WIDTH | Pin weak pull-up enables |
| halt_req | output | 1 | One-cycle HALT request |
| idle_req | output | 1 | One-cycle IDLE request |
| sk_alt_phase | output | 1 | Serial clock alternate phase select |
| halt_start_dly | output | 1 | Clock start-up delay enable after HALT |

## Verification
All four cfg/data combinations are applied on every bit at once with patterns such as 0x0F/0x35 and their complements. A bit that swaps the meaning of cfg and data, or that depends on a neighbouring bit, then shows a mismatch. Data writes with the top bits set, clear and repeated back-to-back separate a true one-cycle strobe from a stored bit or a stretched pulse. Stepped pad_in patterns read at address 2 expose a synchroniser that is too short or too long. Toggling the watchdog select and level while the pin 1 register bits vary shows whether the takeover, and its release, override exactly pin 1. A second, plain instance driven by the same bus checks that the special bits exist only in the control variant.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_DAT = 2'd1;
  localparam logic [1:0] ADDR_PIN = 2'd2;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
  } pin_drv_t;

  // cfg selects driver on/off; dat gives the level, or the pull-up when not driving
  function automatic pin_drv_t decode_pin(input logic cfg, input logic dat);
    pin_drv_t d;
    d.oe  = cfg;
    d.out = cfg & dat;
    d.pu  = ~cfg & dat;
    return d;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_port_pkg::*;
(
  input  logic cfg_bit,
  input  logic dat_bit,
  input  logic force_off,
  input  logic take_wdog,
  input  logic wdog_level,
  output logic pin_out,
  output logic pin_oe,
  output logic pin_pu
);
  pin_drv_t drv;

  always_comb begin
    drv = decode_pin(cfg_bit, dat_bit);
    if (force_off) begin
      drv = '0;
    end else if (take_wdog) begin
      drv.oe  = 1'b1;
      drv.out = wdog_level;
      drv.pu  = 1'b1;
    end
  end

  assign pin_out = drv.out;
  assign pin_oe  = drv.oe;
  assign pin_pu  = drv.pu;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter bit CTRL_PORT = 1'b1,
  parameter int WDOG_BIT  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             wdog_sel,
  input  logic             wdog_level,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu,
  output logic             halt_req,
  output logic             idle_req,
  output logic             sk_alt_phase,
  output logic             halt_start_dly
);
  localparam int HALT_BIT = WIDTH - 1;
  localparam int IDLE_BIT = WIDTH - 2;
  localparam logic [WIDTH-1:0] SPECIAL_MASK =
    CTRL_PORT ? ({{(WIDTH-2){1'b0}}, 2'b11} << IDLE_BIT) : '0;
  localparam logic [WIDTH-1:0] DAT_KEEP = ~SPECIAL_MASK;

  logic [WIDTH-1:0] cfg_q;
  logic [WIDTH-1:0] dat_q;
  logic [WIDTH-1:0] pin_sync;
  logic             wr_cfg;
  logic             wr_dat;
  logic             halt_q;
  logic             idle_q;

  assign wr_cfg = bus_we && (bus_addr == ADDR_CFG);
  assign wr_dat = bus_we && (bus_addr == ADDR_DAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      dat_q  <= '0;
      halt_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata;
      if (wr_dat) dat_q <= bus_wdata & DAT_KEEP;
      halt_q <= CTRL_PORT && wr_dat && bus_wdata[HALT_BIT];
      idle_q <= CTRL_PORT && wr_dat && bus_wdata[IDLE_BIT];
    end
  end

  gpio_sync #(.WIDTH(WIDTH)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_CFG: bus_rdata = cfg_q;
      ADDR_DAT: bus_rdata = dat_q;
      ADDR_PIN: bus_rdata = pin_sync;
      default:  bus_rdata = '0;
    endcase
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      localparam bit FORCE_OFF = CTRL_PORT && (i >= IDLE_BIT);
      localparam bit WDOG_PIN  = CTRL_PORT && (i == WDOG_BIT);
      gpio_pin_cell i_cell (
        .cfg_bit    (cfg_q[i]),
        .dat_bit    (dat_q[i]),
        .force_off  (FORCE_OFF),
        .take_wdog  (WDOG_PIN && wdog_sel),
        .wdog_level (wdog_level),
        .pin_out    (pad_out[i]),
        .pin_oe     (pad_oe[i]),
        .pin_pu     (pad_pu[i])
      );
    end
  endgenerate

  assign halt_req       = halt_q;
  assign idle_req       = idle_q;
  assign sk_alt_phase   = CTRL_PORT ? cfg_q[IDLE_BIT] : 1'b0;
  assign halt_start_dly = CTRL_PORT ? cfg_q[HALT_BIT] : 1'b0;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH     = 8,
  parameter bit CTRL_PORT = 1'b1,
  parameter int WDOG_BIT  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_we,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic             wdog_sel,
  input logic             wdog_level,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pu,
  input logic             halt_req,
  input logic [WIDTH-1:0] cfg_q,
  input logic [WIDTH-1:0] dat_q
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (cfg_q == '0 && dat_q == '0 && pad_oe == '0));

  p_cfg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0) |=> cfg_q == $past(bus_wdata));

  p_pin_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && bus_addr == 2'd2) |-> bus_rdata == $past(pad_in, 2));

  p_halt_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> (CTRL_PORT && $past(bus_we && bus_addr == 2'd1 && bus_wdata[WIDTH-1])));

  p_dat_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (CTRL_PORT && bus_addr == 2'd1) |-> bus_rdata[WIDTH-1 -: 2] == 2'b00);

  p_top_pins_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    CTRL_PORT |-> (pad_oe[WIDTH-1 -: 2] == 2'b00 && pad_pu[WIDTH-1 -: 2] == 2'b00));

  p_wdog_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (CTRL_PORT && wdog_sel) |->
      (pad_oe[WDOG_BIT] && pad_pu[WDOG_BIT] && pad_out[WDOG_BIT] == wdog_level));
endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH(WIDTH), .CTRL_PORT(CTRL_PORT), .WDOG_BIT(WDOG_BIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_sel(wdog_sel),
  .wdog_level(wdog_level), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .halt_req(halt_req),
  .cfg_q(cfg_q), .dat_q(dat_q)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       wdog_sel = 1'b0;
  logic       wdog_level = 1'b0;
  logic [7:0] pad_in = 8'h00;

  logic [7:0] c_rdata, c_out, c_oe, c_pu;
  logic       c_halt, c_idle, c_sk, c_dly;
  logic [7:0] p_rdata, p_out, p_oe, p_pu;
  logic       p_halt, p_idle, p_sk, p_dly;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gpio_port #(.WIDTH(8), .CTRL_PORT(1'b1), .WDOG_BIT(1)) i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(c_rdata), .wdog_sel(wdog_sel),
    .wdog_level(wdog_level), .pad_in(pad_in), .pad_out(c_out), .pad_oe(c_oe),
    .pad_pu(c_pu), .halt_req(c_halt), .idle_req(c_idle),
    .sk_alt_phase(c_sk), .halt_start_dly(c_dly)
  );

  gpio_port #(.WIDTH(8), .CTRL_PORT(1'b0), .WDOG_BIT(1)) i_gpio_port_plain (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(p_rdata), .wdog_sel(wdog_sel),
    .wdog_level(wdog_level), .pad_in(pad_in), .pad_out(p_out), .pad_oe(p_oe),
    .pad_pu(p_pu), .halt_req(p_halt), .idle_req(p_idle),
    .sk_alt_phase(p_sk), .halt_start_dly(p_dly)
  );

  // Reference model: index 0 = control variant, index 1 = plain variant
  logic [7:0] m_cfg [2];
  logic [7:0] m_dat [2];
  logic       m_halt, m_idle;
  logic [7:0] m_pipe [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin m_cfg[k] <= 8'h00; m_dat[k] <= 8'h00; end
      m_halt <= 1'b0;
      m_idle <= 1'b0;
      m_pipe = {8'h00, 8'h00};
    end else begin
      if (bus_we && bus_addr == 2'd0) begin
        m_cfg[0] <= bus_wdata; m_cfg[1] <= bus_wdata;
      end
      if (bus_we && bus_addr == 2'd1) begin
        m_dat[0] <= {2'b00, bus_wdata[5:0]}; m_dat[1] <= bus_wdata;
      end
      m_halt <= bus_we && bus_addr == 2'd1 && bus_wdata[7];
      m_idle <= bus_we && bus_addr == 2'd1 && bus_wdata[6];
      m_pipe.push_back(pad_in);
      void'(m_pipe.pop_front());
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int k);
    case (bus_addr)
      2'd0: return m_cfg[k];
      2'd1: return m_dat[k];
      2'd2: return m_pipe[0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk_pins(input int k, input logic [7:0] o, input logic [7:0] e, input logic [7:0] u);
    for (int i = 0; i < 8; i++) begin
      logic xo, xe, xu;
      string req;
      req = (k == 1) ? "R9" : "R2";
      if (m_cfg[k][i]) begin xe = 1; xo = m_dat[k][i]; xu = 0; end
      else begin xe = 0; xo = 0; xu = m_dat[k][i]; end
      if (k == 0 && i >= 6) begin xe = 0; xo = 0; xu = 0; req = "R7"; end
      else if (k == 0 && i == 1 && wdog_sel) begin xe = 1; xo = wdog_level; xu = 1; req = "R8"; end
      chk(req, $sformatf("inst%0d pin%0d {oe,out,pu}", k, i), {e[i], o[i], u[i]}, {xe, xo, xu});
    end
  endtask

  // Compare every cycle, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(bus_addr == 2'd2 ? "R4" : "R3", "ctrl rdata", c_rdata, exp_rd(0));
      chk(bus_addr == 2'd2 ? "R4" : "R9", "plain rdata", p_rdata, exp_rd(1));
      if (bus_addr == 2'd1) chk("R5", "ctrl rdata[7:6]", c_rdata[7:6], 0);
      chk_pins(0, c_out, c_oe, c_pu);
      chk_pins(1, p_out, p_oe, p_pu);
      chk("R5", "halt_req", c_halt, m_halt);
      chk("R5", "idle_req", c_idle, m_idle);
      chk("R6", "sk_alt_phase", c_sk, m_cfg[0][6]);
      chk("R6", "halt_start_dly", c_dly, m_cfg[0][7]);
      chk("R9", "plain strobes/options", {p_halt, p_idle, p_sk, p_dly}, 0);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1", "reset pad_oe|pad_pu|pad_out", c_oe | c_pu | c_out | p_oe | p_pu | p_out, 0);
        chk("R1", "reset strobes", {c_halt, c_idle, c_sk, c_dly}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cfg after reset", c_rdata, 0);
        rd(2'd1);
        chk("R1", "data after reset", c_rdata, 0);
        // R2/R3: mixed modes per bit, independence
        wr(2'd0, 8'h0F); wr(2'd1, 8'h35); rd(2'd0); rd(2'd1);
        wr(2'd0, 8'hF0); wr(2'd1, 8'hCA); rd(2'd1);
        wr(2'd0, 8'h5A); wr(2'd1, 8'h3C); rd(2'd0); rd(2'd3);
        // R4: synchroniser and ignored writes
        @(negedge clk); pad_in = 8'hA5; bus_addr = 2'd2;
        @(negedge clk); pad_in = 8'h3C;
        @(negedge clk); pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        wr(2'd2, 8'h00); rd(2'd0); rd(2'd1); rd(2'd2);
        // R5: strobes, back-to-back, not retained
        wr(2'd1, 8'hC0); wr(2'd1, 8'h80); wr(2'd1, 8'h40); wr(2'd1, 8'h3F); rd(2'd1);
        @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'hFF; bus_we = 1'b1;
        @(negedge clk); bus_wdata = 8'h80;
        @(negedge clk); bus_we = 1'b0;
        @(negedge clk);
        // R6/R7: option bits; top pins stay off
        wr(2'd0, 8'h40); wr(2'd0, 8'h80); wr(2'd0, 8'hFF); rd(2'd0);
        // R8: watchdog takeover with varying pin 1 bits
        @(negedge clk); wdog_sel = 1'b1; wdog_level = 1'b0;
        wr(2'd0, 8'h02); wr(2'd1, 8'h00);
        @(negedge clk); wdog_level = 1'b1;
        wr(2'd0, 8'h00); wr(2'd1, 8'h02);
        @(negedge clk); wdog_level = 1'b0;
        @(negedge clk);
        // R10: release returns pin 1 to register control (cfg=0,data=1 -> pull-up input)
        wdog_sel = 1'b0; wdog_level = 1'b1;
        @(negedge clk);
        chk("R10", "pin1 {oe,out,pu} after release", {c_oe[1], c_out[1], c_pu[1]}, 3'b001);
        wr(2'd0, 8'h02);
        chk("R10", "pin1 driven high from regs", {c_oe[1], c_out[1], c_pu[1]}, 3'b110);
        repeat (4) @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule